// File: doc/BRIEF.md
# External Interrupt Sense Converter

This block sits between a set of external interrupt pins and a downstream interrupt controller that accepts only active-high level requests. Each of its lines can be programmed to respond to a high level, a low level, a rising edge or a falling edge. Every pin passes through a two-flop synchronizer. The synchronized value is qualified by the line's polarity and sense mode. The result is held in a per-line raw request bit, which is gated by a per-line mask and driven out as a level request.

Software reaches the block through a single-cycle read/write port with word-aligned byte addresses. The port holds the mask, polarity and sense-mode controls. It also reads back raw and masked request status and takes write-one-to-clear commands. Two further words, a source-select word and a software-interrupt word, are plain storage with no effect on the request path. An edge request is latched whether or not the line is masked. Unmasking a line later therefore presents any edge that arrived while it was masked.

Top module: `irq_sense_conv`

## Requirements
- R1: After a synchronous reset the mask word reads all ones, polarity reads all ones, sense mode and raw status read zero, both storage words read zero, and every irq_out bit is 0.
- R2: irq_out[i] is 1 exactly when raw request bit i is 1 and mask bit i is 0. A mask bit of 1 blocks the line.
- R3: A level-sensed line (mode bit 0) sets its raw bit to the pin level when its polarity bit is 1, and to the inverted pin level when its polarity bit is 0. A pin change that is sampled at one rising clock edge reaches the raw bit at the third rising edge.
- R4: An edge-sensed line (mode bit 1) sets its raw bit on a rising pin transition when polarity is 1 and on a falling transition when polarity is 0. A transition in the opposite direction does not set it.
- R5: An edge request is latched while the line is masked. Clearing the mask bit then raises irq_out for that line without any further pin activity.
- R6: Writing the clear word (byte offset 0x10) drops every edge-latched raw bit whose write data bit is 1. Bits written as 0 are unaffected.
- R7: A clear write has no lasting effect on a level-sensed line whose qualified level is still active.
- R8: When a clear write and a new qualifying edge reach the same line in the same cycle, the raw bit stays set.
- R9: Reads return, by byte offset: 0x00 mask, 0x04 source-select storage, 0x08 raw AND NOT mask, 0x0C raw, 0x10 zero, 0x14 polarity, 0x18 sense mode, 0x1C software-interrupt storage. A read with bus_sel low or an unaligned address returns zero.
- R10: Writes to offsets 0x08 and 0x0C change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | N_LINES | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data, combinational from bus_addr |
| irq_out | output | N_LINES | Active-high level requests to the downstream controller |

## Verification
The bench aims at five corner cases. The first is a clear write that lands in the same cycle as a fresh edge; a design that let the clear win would drop an interrupt. The second is an edge that arrives on a masked line; a design that gated the latch with the mask would never raise the request after unmasking. The third is a clear written to a level line whose pin is still active; a design that let the clear stick would lose a live request. The fourth is a transition in the wrong direction on an edge line; it exposes inverted polarity decoding. The fifth is a write to the read-only status offsets and to bits written as zero in the clear word; these expose address decode that corrupts state.

// File: rtl/irqsc_pkg.sv
// Shared definitions for the interrupt sense converter.
// Assumes a 32-byte register window of word-aligned registers.
package irqsc_pkg;

    localparam int unsigned BUS_AW     = 5;
    localparam int unsigned WORD_SHIFT = 2;
    localparam int unsigned IDX_W      = BUS_AW - WORD_SHIFT;

    typedef enum logic [IDX_W-1:0] {
        RSEL_MASK = 3'd0,
        RSEL_SRC  = 3'd1,
        RSEL_PEND = 3'd2,
        RSEL_RAW  = 3'd3,
        RSEL_CLR  = 3'd4,
        RSEL_POL  = 3'd5,
        RSEL_MODE = 3'd6,
        RSEL_SWI  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic src;
        logic clr;
        logic pol;
        logic mode;
        logic swi;
    } wr_strobe_t;

    // Split a byte address into word select and alignment flag.
    function automatic reg_sel_e addr_to_sel(input logic [BUS_AW-1:0] addr);
        return reg_sel_e'(addr[BUS_AW-1:WORD_SHIFT]);
    endfunction

    function automatic logic addr_aligned(input logic [BUS_AW-1:0] addr);
        return addr[WORD_SHIFT-1:0] == '0;
    endfunction

endpackage

// File: rtl/irqsc_sync.sv
// Multi-stage synchronizer, one chain per line.
// Assumes each input bit is an independent asynchronous signal; no
// cross-bit coherency is implied.
module irqsc_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stage_q [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    // Remaining stages shift the sample along the chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irqsc_sense.sv
// Per-line polarity qualifier and edge detector.
// Assumes sync_in is already in the clk domain. The previous-value flop
// resets to zero, so a pin that is high at reset yields one rising event.
module irqsc_sense #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] pol,
    output logic [N-1:0] lvl,
    output logic [N-1:0] evt
);

    logic [N-1:0] prev_q;

    // Remember last cycle's synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic rise;
        logic fall;
        assign rise   = sync_in[i] & ~prev_q[i];
        assign fall   = ~sync_in[i] & prev_q[i];
        assign lvl[i] = pol[i] ? sync_in[i] : ~sync_in[i];
        assign evt[i] = pol[i] ? rise : fall;
    end

endmodule

// File: rtl/irqsc_latch.sv
// Raw request storage. Edge lines set on an event and hold until
// cleared, with a simultaneous event winning. Level lines copy the
// qualified level every cycle.
// Assumes clr is a one-cycle pulse vector.
module irqsc_latch #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);

    logic [N-1:0] raw_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Update one line's request bit according to its sense mode.
        always_ff @(posedge clk) begin
            if (!rst_n)       raw_q[i] <= 1'b0;
            else if (mode[i]) raw_q[i] <= evt[i] | (raw_q[i] & ~clr[i]);
            else              raw_q[i] <= lvl[i];
        end
    end

    assign raw = raw_q;

endmodule

// File: rtl/irqsc_regs.sv
// Control register file and read mux for the sense converter.
// Assumes single-cycle accesses qualified by sel; reads are combinational.
// Status offsets are read-only, and the clear offset reads as zero.
module irqsc_regs
    import irqsc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      raw,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      mode_q,
    output logic [N-1:0]      clr_vec
);

    reg_sel_e     rsel;
    logic         hit;
    wr_strobe_t   stb;
    logic [N-1:0] src_q;
    logic [N-1:0] swi_q;

    assign rsel = addr_to_sel(addr);
    assign hit  = sel & addr_aligned(addr);

    // Decode write strobes for the writable words.
    always_comb begin
        stb      = '0;
        if (hit && wr) begin
            case (rsel)
                RSEL_MASK: stb.mask = 1'b1;
                RSEL_SRC:  stb.src  = 1'b1;
                RSEL_CLR:  stb.clr  = 1'b1;
                RSEL_POL:  stb.pol  = 1'b1;
                RSEL_MODE: stb.mode = 1'b1;
                RSEL_SWI:  stb.swi  = 1'b1;
                default:   stb      = '0;
            endcase
        end
    end

    assign clr_vec = stb.clr ? wdata : '0;

    // Mask register: all lines blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (stb.mask) mask_q <= wdata;
    end

    // Polarity register: active-high sensing out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       pol_q <= '1;
        else if (stb.pol) pol_q <= wdata;
    end

    // Sense-mode register: level sensing out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= '0;
        else if (stb.mode) mode_q <= wdata;
    end

    // Source-select storage word, no function on the request path.
    always_ff @(posedge clk) begin
        if (!rst_n)       src_q <= '0;
        else if (stb.src) src_q <= wdata;
    end

    // Software-interrupt storage word, no function on the request path.
    always_ff @(posedge clk) begin
        if (!rst_n)       swi_q <= '0;
        else if (stb.swi) swi_q <= wdata;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (hit && !wr) begin
            case (rsel)
                RSEL_MASK: rdata = mask_q;
                RSEL_SRC:  rdata = src_q;
                RSEL_PEND: rdata = raw & ~mask_q;
                RSEL_RAW:  rdata = raw;
                RSEL_CLR:  rdata = '0;
                RSEL_POL:  rdata = pol_q;
                RSEL_MODE: rdata = mode_q;
                RSEL_SWI:  rdata = swi_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_sense_conv.sv
// Top of the external interrupt sense converter. It synchronizes the
// pins, qualifies them per line, latches requests and gates them with
// the mask to form level-high outputs.
// Assumes the downstream controller samples irq_out as a level.
module irq_sense_conv
    import irqsc_pkg::*;
#(
    parameter int unsigned N_LINES     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic [N_LINES-1:0] irq_out
);

    logic [N_LINES-1:0] sync_vec;
    logic [N_LINES-1:0] lvl_vec;
    logic [N_LINES-1:0] evt_vec;
    logic [N_LINES-1:0] raw_q;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] pol_q;
    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] clr_vec;

    irqsc_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (sync_vec)
    );

    irqsc_sense #(.N(N_LINES)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_vec),
        .pol     (pol_q),
        .lvl     (lvl_vec),
        .evt     (evt_vec)
    );

    irqsc_latch #(.N(N_LINES)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .lvl   (lvl_vec),
        .evt   (evt_vec),
        .clr   (clr_vec),
        .raw   (raw_q)
    );

    irqsc_regs #(.N(N_LINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .raw     (raw_q),
        .rdata   (bus_rdata),
        .mask_q  (mask_q),
        .pol_q   (pol_q),
        .mode_q  (mode_q),
        .clr_vec (clr_vec)
    );

    assign irq_out = raw_q & ~mask_q;

endmodule

// File: rtl/irqsc_chk.sv
// Assertion checker for the sense converter, bound to the top module.
// Assumes the reset is held for at least one clock before release.
module irqsc_chk #(
    parameter int unsigned N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] irq_out,
    input logic [N-1:0] mask_q,
    input logic [N-1:0] raw_q,
    input logic [N-1:0] mode_q,
    input logic [N-1:0] lvl_vec,
    input logic [N-1:0] evt_vec,
    input logic [N-1:0] clr_vec
);

    // R2
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & (mask_q | ~raw_q)) == '0) && ((raw_q & ~mask_q & ~irq_out) == '0));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_q & mode_q & ~clr_vec) & ~raw_q) == '0));

    // R6
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mode_q & clr_vec & ~evt_vec) & raw_q) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mode_q & evt_vec) & ~raw_q) == '0));

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~mode_q) & (raw_q ^ $past(lvl_vec))) == '0));

endmodule

bind irq_sense_conv irqsc_chk #(.N(N_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .mode_q  (mode_q),
    .lvl_vec (lvl_vec),
    .evt_vec (evt_vec),
    .clr_vec (clr_vec)
);

// File: tb/irq_sense_conv_bench.sv
module irq_sense_conv_bench;

    localparam int CLK_PER = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    logic [N-1:0] m_mask, m_pol, m_mode, m_raw, m_src, m_swi;
    logic [N-1:0] hist[$];

    always #(CLK_PER/2) clk = ~clk;

    irq_sense_conv u_irq_sense_conv (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_read();
        if (!bus_sel || bus_wr) return '0;
        case (bus_addr)
            5'h00: return m_mask;
            5'h04: return m_src;
            5'h08: return m_raw & ~m_mask;
            5'h0C: return m_raw;
            5'h14: return m_pol;
            5'h18: return m_mode;
            5'h1C: return m_swi;
            default: return '0;
        endcase
    endfunction

    // Behavioural reference: pin history queue plus request bits, checked each clock.
    always @(posedge clk) begin
        logic [N-1:0] s, p, clrv;
        if (!rst_n) begin
            m_mask = '1; m_pol = '1; m_mode = '0; m_raw = '0; m_src = '0; m_swi = '0;
            hist = '{32'h0, 32'h0, 32'h0};
            model_on = 1'b1;
        end else if (model_on) begin
            s = hist[1];
            p = hist[0];
            clrv = (bus_sel && bus_wr && bus_addr == 5'h10) ? bus_wdata : '0;
            for (int i = 0; i < N; i++) begin
                if (m_mode[i]) begin
                    bit ev;
                    ev = m_pol[i] ? (s[i] && !p[i]) : (!s[i] && p[i]);
                    m_raw[i] = ev || (m_raw[i] && !clrv[i]);
                end else begin
                    m_raw[i] = m_pol[i] ? s[i] : !s[i];
                end
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    5'h00: m_mask = bus_wdata;
                    5'h04: m_src  = bus_wdata;
                    5'h14: m_pol  = bus_wdata;
                    5'h18: m_mode = bus_wdata;
                    5'h1C: m_swi  = bus_wdata;
                    default: ;
                endcase
            end
            void'(hist.pop_front());
            hist.push_back(line_in);
        end
        #(CLK_PER/4);
        if (model_on && rst_n) begin
            chk("R2 irq_out vs model", irq_out, m_raw & ~m_mask);
            chk("R9 rdata vs model", bus_rdata, model_read());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [N-1:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_out after reset", irq_out, '0);
        rd_chk("R1 mask reset", 5'h00, 32'hFFFF_FFFF);
        rd_chk("R1 pol reset", 5'h14, 32'hFFFF_FFFF);
        rd_chk("R1 mode reset", 5'h18, 32'h0);
        rd_chk("R1 raw reset", 5'h0C, 32'h0);
        rd_chk("R1 swi reset", 5'h1C, 32'h0);

        // R3 level-high on line 0
        wr(5'h00, 32'hFFFF_FFFE);
        line_in[0] = 1'b1;
        idle(4);
        chk("R3 level high asserted", {31'b0, irq_out[0]}, 32'h1);
        line_in[0] = 1'b0;
        idle(4);
        chk("R3 level high released", {31'b0, irq_out[0]}, 32'h0);

        // R3 level-low on line 1
        wr(5'h14, 32'hFFFF_FFFD);
        wr(5'h00, 32'hFFFF_FFFC);
        idle(2);
        chk("R3 level low asserted", {31'b0, irq_out[1]}, 32'h1);
        line_in[1] = 1'b1;
        idle(4);
        chk("R3 level low released", {31'b0, irq_out[1]}, 32'h0);

        // R7 clear on an active level line
        line_in[0] = 1'b1;
        idle(4);
        wr(5'h10, 32'h1);
        chk("R7 level survives clear", {31'b0, irq_out[0]}, 32'h1);
        idle(3);
        rd_chk("R7 raw after clear", 5'h0C, 32'h1);

        // R4 rising edge on line 2
        wr(5'h18, 32'h4);
        wr(5'h00, 32'hFFFF_FFF8);
        line_in[2] = 1'b1;
        idle(1);
        line_in[2] = 1'b0;
        idle(5);
        chk("R4 rising edge latched", {31'b0, irq_out[2]}, 32'h1);
        wr(5'h10, 32'h4);
        chk("R6 clear edge line 2", {31'b0, irq_out[2]}, 32'h0);

        // R4 falling edge on line 3
        wr(5'h18, 32'hC);
        wr(5'h14, 32'hFFFF_FFF5);
        wr(5'h00, 32'hFFFF_FFF0);
        line_in[3] = 1'b1;
        idle(5);
        chk("R4 wrong direction ignored", {31'b0, irq_out[3]}, 32'h0);
        line_in[3] = 1'b0;
        idle(5);
        chk("R4 falling edge latched", {31'b0, irq_out[3]}, 32'h1);

        // R5 edge on masked line 4
        wr(5'h18, 32'h1C);
        line_in[4] = 1'b1;
        idle(1);
        line_in[4] = 1'b0;
        idle(5);
        chk("R5 masked output low", {31'b0, irq_out[4]}, 32'h0);
        rd_chk("R5 raw holds masked edge", 5'h0C, 32'h19);
        rd_chk("R9 pending excludes masked", 5'h08, 32'h09);
        wr(5'h00, 32'hFFFF_FFE0);
        chk("R5 unmask presents edge", {31'b0, irq_out[4]}, 32'h1);

        // R6 zero bits have no effect, one bit clears
        wr(5'h10, 32'h0);
        chk("R6 zero clear keeps requests", irq_out & 32'h1F, 32'h19);
        wr(5'h10, 32'h10);
        chk("R6 selective clear", irq_out & 32'h1F, 32'h09);

        // R8 clear and edge in the same cycle on line 5
        wr(5'h18, 32'h3C);
        wr(5'h00, 32'hFFFF_FFC0);
        line_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h20;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        chk("R8 edge wins over clear", {31'b0, irq_out[5]}, 32'h1);
        wr(5'h10, 32'h20);
        chk("R6 later clear drops line 5", {31'b0, irq_out[5]}, 32'h0);

        // R9 storage words and clear readback
        wr(5'h04, 32'hA5A5_0F0F);
        wr(5'h1C, 32'h0000_1234);
        rd_chk("R9 source select storage", 5'h04, 32'hA5A5_0F0F);
        rd_chk("R9 software word storage", 5'h1C, 32'h0000_1234);
        rd_chk("R9 clear reads zero", 5'h10, 32'h0);
        rd_chk("R9 unaligned reads zero", 5'h02, 32'h0);

        // R10 status offsets are read-only
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        rd_chk("R10 raw unchanged", 5'h0C, 32'h09);
        rd_chk("R10 mask unchanged", 5'h00, 32'hFFFF_FFC0);
        chk("R10 outputs unchanged", irq_out, 32'h09);

        idle(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule